// File: doc/BRIEF.md
# Two-Stage SCL Clock Prescaler

This block derives the serial clock timing of an I2C master from the system clock. Two divisors are taken from one configuration word. A 2-bit divisor A sets a first stage that divides the system clock by (A+1). The carry of that stage steps a second stage, which divides by (B+1) using a 6-bit divisor B. Each carry of the second stage is one prescaled tick. A half-phase counter then splits every SCL period into a low half and a high half of 11 prescaled ticks each. The resulting SCL frequency is the system clock divided by 22 × (A+1) × (B+1).

The bit engine uses two outputs. `qtr_tick` is an enable pulse that fires twice in each half. The first pulse marks the middle of the half and the second marks its end. `scl_phase` is a free-running indication of the SCL level, and `scl_drive_low` is the open-drain pull-down derived from it. A write of the configuration word clears all three counters, so the first SCL half after the write always has its full length.

A slave may stretch the clock by holding SCL low. While the block has released SCL but samples it low, the half-phase counter waits. With a 100 MHz system clock, the divisors are chosen so that SCL stays at or below 400 kHz. The largest divide, 4 × 64 × 22, gives a little under 18 kHz.

Top module: `scl_prescaler`

## Requirements
- R1: While reset is held and in the first cycle after it, `scl_phase` is 1 (SCL released), `scl_drive_low` is 0 and `qtr_tick` is 0.
- R2: Divisor B is taken from `cfg_data[13:8]` and divisor A from `cfg_data[15:14]` when `cfg_we` is 1. Bits 7:0 of the word have no effect on the timing.
- R3: Without stretching, each SCL half (low or high) lasts exactly 11 × (A+1) × (B+1) clock cycles, so the period is 22 × (A+1) × (B+1).
- R4: The divide applies the product of both stages for every value of A (0..3) and B (0..63), including the minimum (A=0, B=0) and the maximum (A=3, B=63).
- R5: `qtr_tick` is a one-cycle pulse that occurs twice per half. It fires on the 6th and 11th prescaled tick of each half, so consecutive pulses are 6 × D and 5 × D cycles apart, alternating, where D = (A+1)(B+1). Two consecutive cycles never both carry the pulse.
- R6: `scl_phase` changes only in the cycle after an end-of-half `qtr_tick`, and it alternates between the two halves.
- R7: A configuration write clears both divisor counters and the half counter. The next `scl_phase` change therefore comes exactly 11 × D cycles after the write edge, where D uses the new divisors, and no `qtr_tick` occurs in the cycle after the write.
- R8: While `scl_phase` is 1 and `scl_in` is 0, the half counter does not advance and `scl_phase` stays 1. The high half is lengthened by the stretch time, to within one prescaled tick.
- R9: A low `scl_in` during the low half has no effect, and that half still lasts 11 × D cycles.
- R10: `scl_drive_low` is always the inverse of `scl_phase`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe; loads divisors and restarts counters |
| cfg_data | input | 16 | Configuration word; B in bits 13:8, A in bits 15:14 |
| scl_in | input | 1 | Sampled level of the SCL line |
| qtr_tick | output | 1 | Mid-half and end-of-half enable pulse for the bit engine |
| scl_phase | output | 1 | Current SCL half: 1 high, 0 low |
| scl_drive_low | output | 1 | Open-drain pull-down request for SCL |

## Verification
A wrong divisor count or a misplaced field changes the distance between `scl_phase` edges by a multiple of the prescaled tick. That error shows within one half, at most 2816 cycles. A half counter that is off by one moves the mid-half `qtr_tick` and breaks the 6:5 spacing at the first pulse after a phase edge. A restart that misses a counter makes the first half after a write too short, which is visible at its first edge. A stretch path that is wrong lets `scl_phase` fall while SCL is held low, or lengthens a low half, in the half where it happens.

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int CFG_W      = 16,
  parameter int DIVA_W     = 2,
  parameter int DIVB_W     = 6,
  parameter int DIVA_LSB   = 14,
  parameter int DIVB_LSB   = 8,
  parameter int HALF_TICKS = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_data,
  input  logic             scl_in,
  output logic             qtr_tick,
  output logic             scl_phase,
  output logic             scl_drive_low
);
  localparam int PH_W = $clog2(HALF_TICKS);
  localparam logic [PH_W-1:0] MID_CNT = PH_W'(HALF_TICKS / 2);
  localparam logic [PH_W-1:0] END_CNT = PH_W'(HALF_TICKS - 1);

  logic [DIVA_W-1:0] div_a, cnt_a;
  logic [DIVB_W-1:0] div_b, cnt_b;
  logic [PH_W-1:0]   cnt_p;
  logic              a_wrap, pre_tick, stall, advance, half_end;
  logic              unused_low_bits;

  assign unused_low_bits = ^cfg_data[DIVB_LSB-1:0];

  assign a_wrap   = (cnt_a == div_a);
  assign pre_tick = a_wrap && (cnt_b == div_b);
  assign stall    = scl_phase && !scl_in;
  assign advance  = pre_tick && !stall;
  assign half_end = advance && (cnt_p == END_CNT);
  assign qtr_tick = advance && ((cnt_p == MID_CNT) || (cnt_p == END_CNT));
  assign scl_drive_low = !scl_phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_a <= '0;
      div_b <= '0;
    end else if (cfg_we) begin
      div_a <= cfg_data[DIVA_LSB +: DIVA_W];
      div_b <= cfg_data[DIVB_LSB +: DIVB_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || cfg_we) begin
      cnt_a <= '0;
      cnt_b <= '0;
    end else if (a_wrap) begin
      cnt_a <= '0;
      cnt_b <= (cnt_b == div_b) ? '0 : cnt_b + 1'b1;
    end else begin
      cnt_a <= cnt_a + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_p     <= '0;
      scl_phase <= 1'b1;
    end else if (cfg_we) begin
      cnt_p <= '0;
    end else if (half_end) begin
      cnt_p     <= '0;
      scl_phase <= !scl_phase;
    end else if (advance) begin
      cnt_p <= cnt_p + 1'b1;
    end
  end

  // R6
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_phase != $past(scl_phase)) |-> $past(qtr_tick));

  // R8
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_phase && !scl_in) |=> scl_phase);

  // R7
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !qtr_tick);

  // R5
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    qtr_tick |=> !qtr_tick);
endmodule

// File: tb/test_scl_prescaler.sv
module test_scl_prescaler;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_data = '0;
  logic        stretch = 1'b0;
  logic        scl_in;
  logic        qtr_tick, scl_phase, scl_drive_low;
  int          cyc = 0;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign scl_in = !(scl_drive_low || stretch);

  scl_prescaler i_scl_prescaler (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_data(cfg_data),
    .scl_in(scl_in), .qtr_tick(qtr_tick), .scl_phase(scl_phase),
    .scl_drive_low(scl_drive_low));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_toggle(output int t);
    logic prev;
    prev = scl_phase;
    do begin
      @(negedge clk);
      check(scl_drive_low == !scl_phase, "R10", int'(scl_drive_low), int'(!scl_phase));
    end while (scl_phase == prev);
    t = cyc;
  endtask

  task automatic wait_qtr(output int t);
    do @(negedge clk); while (!qtr_tick);
    t = cyc;
  endtask

  task automatic write_cfg(input int a, input int b, input logic [7:0] low, output int t0);
    @(negedge clk);
    cfg_data = {a[1:0], b[5:0], low};
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    t0 = cyc;
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(scl_phase == 1'b1, "R1 phase", int'(scl_phase), 1);
    check(scl_drive_low == 1'b0, "R1 drive", int'(scl_drive_low), 0);
    check(qtr_tick == 1'b0, "R1 tick", int'(qtr_tick), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(scl_phase == 1'b1 && qtr_tick == 1'b0, "R1 first cycle", int'(scl_phase), 1);
  endtask

  task automatic test_period(input int a, input int b, input logic [7:0] low, input string req);
    int d, t0, t1, t2, t3;
    logic p1;
    d = (a + 1) * (b + 1);
    write_cfg(a, b, low, t0);
    wait_toggle(t1);
    check(t1 - t0 == 11 * d, {req, " R7 restart"}, t1 - t0, 11 * d);
    p1 = scl_phase;
    wait_toggle(t2);
    check(t2 - t1 == 11 * d, {req, " R3 half"}, t2 - t1, 11 * d);
    check(scl_phase == !p1, "R6 alternate", int'(scl_phase), int'(!p1));
    wait_toggle(t3);
    check(t3 - t2 == 11 * d, {req, " R3 R4 half"}, t3 - t2, 11 * d);
  endtask

  task automatic test_quarter(input int a, input int b);
    int d, t0, t, q1, q2, q3;
    d = (a + 1) * (b + 1);
    write_cfg(a, b, 8'h00, t0);
    wait_toggle(t);
    wait_qtr(q1);
    check(scl_phase == scl_phase && q1 - t == 6 * d - 1, "R5 mid", q1 - t, 6 * d - 1);
    wait_qtr(q2);
    check(q2 - q1 == 5 * d, "R5 end", q2 - q1, 5 * d);
    wait_qtr(q3);
    check(q3 - q2 == 6 * d, "R5 next mid", q3 - q2, 6 * d);
  endtask

  task automatic test_mid_restart();
    int t0, t1, tx;
    write_cfg(1, 1, 8'h00, t0);
    repeat (17) @(negedge clk);
    write_cfg(0, 2, 8'h00, t0);
    wait_toggle(t1);
    check(t1 - t0 == 33, "R7 mid-half write", t1 - t0, 33);
    tx = t1;
  endtask

  task automatic test_stretch();
    int d, t0, t1, t2, t3, s;
    d = 2;
    s = 50;
    write_cfg(1, 0, 8'h00, t0);
    wait_toggle(t1);
    if (scl_phase == 1'b0) begin
      stretch = 1'b1;
      wait_toggle(t2);
      check(t2 - t1 == 11 * d, "R9 low unaffected", t2 - t1, 11 * d);
      repeat (s) @(negedge clk);
      check(scl_phase == 1'b1, "R8 held high", int'(scl_phase), 1);
      stretch = 1'b0;
      wait_toggle(t3);
      check((t3 - t2 >= 11 * d + s - d) && (t3 - t2 <= 11 * d + s + d),
            "R8 stretched high", t3 - t2, 11 * d + s);
    end else begin
      check(1'b0, "R8 phase order", int'(scl_phase), 0);
    end
  endtask

  initial begin
    test_reset();
    test_period(0, 0, 8'h00, "R4 min");
    test_period(3, 0, 8'h00, "R4 A only");
    test_period(0, 5, 8'h00, "R4 B only");
    test_period(2, 3, 8'hFF, "R2 low bits");
    test_period(3, 63, 8'h5A, "R4 max");
    test_quarter(0, 0);
    test_quarter(1, 2);
    test_mid_restart();
    test_stretch();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule